// File: doc/BRIEF.md
# Pipeline Fetch Unit with Branch and Jump Redirect

This block holds the program counter of a three-stage pipeline (fetch, execute, writeback) whose program counter counts instruction words, twelve bits wide. Every cycle it presents the fetch address to an instruction memory. It registers the returned word as the execute-stage instruction, and it keeps the address of that instruction alongside it. The memory is read combinationally from the fetch address, and the block's register acts as the one-cycle read stage.

While the instruction in the execute stage is decoded, the block builds three candidate targets: a conditional branch target, a direct jump-and-link target and a register-indirect jump target. It decides conditional branches from the ALU result that the datapath returns for the instruction. A taken transfer picks the new fetch address through a two-bit select. The word fetched in that same cycle is still registered, but a stall bit marks it as dead, so it can neither redirect nor write a link. Jumps also produce a link value for the register file.

Top module: `fetch_unit`

## Requirements
- R1: While reset is high, the fetch address, the execute-stage address, the execute-stage instruction and the stall bit are all cleared to zero.
- R2: Without a redirect, the fetch address steps up by one per cycle and wraps modulo 2^PC_W. On each clock the execute-stage address takes the previous fetch address, and the execute-stage instruction takes the word on `imem_data`.
- R3: Opcode 1100011 marks a conditional branch. Its byte offset has bit 0 zero, bits 4:1 from instr[11:8], bits 10:5 from instr[30:25], bit 11 from instr[7] and bit 12 (sign) from instr[31]. Its target is the execute-stage address plus offset bits [12:2] sign-extended, modulo 2^PC_W.
- R4: The branch condition comes from instr[14:12] and the ALU result. Code 000 is taken when the result is zero, and 001 when it is nonzero. Codes 100 and 110 are taken when the result equals 1, and 101 and 111 when it equals 0. Codes 010 and 011 are never taken.
- R5: Opcode 1101111 is an unconditional jump-and-link. Its byte offset has bit 0 zero, bits 10:1 from instr[30:21], bit 11 from instr[20], bits 19:12 from instr[19:12] and bit 20 from instr[31]. Its target is the execute-stage address plus offset bits [PC_W+1:2], modulo 2^PC_W.
- R6: Opcode 1100111 with instr[14:12] = 000 is a register jump. Its target is rs1_data[PC_W+1:2] plus instr[31:22] sign-extended, modulo 2^PC_W. Carries from the two low bits are dropped. Any other code under this opcode does not redirect.
- R7: A taken transfer loads its target into the fetch address at the next clock and sets the stall bit for exactly one cycle.
- R8: An instruction whose stall bit is set neither redirects nor asserts the link write, whatever its encoding.
- R9: `link_we` is high only for a non-stalled jump of R5 or R6. `link_data` is then the fetch address as a byte address (fetch address times 4), zero-extended.
- R10: `pc_sel` reads 00 for the sequential path, 01 for a branch, 10 for a direct jump and 11 for a register jump. `redirect` is high exactly when `pc_sel` is nonzero.
- R11: Take a program with two loads of the constants -1 and 2, followed by a mix of taken and untaken branches, direct jumps and register jumps. Its execute stage must visit the words 0,1,2,3,4*,8,9*,4,5*,9,10*,9,10*,10,11,12*,13, where * marks a stalled slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Word address being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| alu_result | input | XLEN | ALU result for the execute-stage instruction |
| rs1_data | input | XLEN | First source register value for the execute-stage instruction |
| pc_ex | output | PC_W | Word address of the execute-stage instruction |
| instr_ex | output | 32 | Execute-stage instruction |
| stall_ex | output | 1 | Execute-stage instruction is dead (no writes) |
| pc_sel | output | 2 | Next-address select: 00 seq, 01 branch, 10 jump, 11 register jump |
| redirect | output | 1 | A transfer is taken this cycle |
| link_we | output | 1 | Write `link_data` to the destination register |
| link_data | output | XLEN | Return byte address |

## Verification
A corrupted fetch register shows up on `imem_addr` at the very next clock, and one cycle later on `pc_ex`. A stall bit that is set wrongly or left set too long appears in the same cycle as a missing redirect or link write for a real jump. A stall bit that fails to set lets a dead jump redirect in the cycle after the taken transfer. A wrong target or a wrong condition decode is visible as soon as the transfer sits in the execute stage, on `pc_sel`, and the next fetch address follows one clock later. The program sequence shows chained redirects one after another, which single-instruction sweeps cannot expose.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int INSTR_W = 32;

  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  localparam logic [2:0] CND_EQ  = 3'b000;
  localparam logic [2:0] CND_NE  = 3'b001;
  localparam logic [2:0] CND_LT  = 3'b100;
  localparam logic [2:0] CND_GE  = 3'b101;
  localparam logic [2:0] CND_LTU = 3'b110;
  localparam logic [2:0] CND_GEU = 3'b111;

  typedef enum logic [1:0] {
    NPC_SEQ    = 2'b00,
    NPC_BRANCH = 2'b01,
    NPC_JAL    = 2'b10,
    NPC_JALR   = 2'b11
  } npc_sel_e;
endpackage

// File: rtl/fetch_target_gen.sv
module fetch_target_gen
  import fetch_pkg::*;
#(
  parameter int PC_W = 12,
  parameter int XLEN = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [PC_W-1:0]    pc_ex,
  input  logic [XLEN-1:0]    rs1_data,
  output logic [PC_W-1:0]    br_tgt,
  output logic [PC_W-1:0]    jal_tgt,
  output logic [PC_W-1:0]    jalr_tgt
);
  localparam int XW = PC_W + 2;

  logic [12:0]   br_off;
  logic [20:0]   jal_off;
  logic [11:0]   jr_imm;
  logic [XW-1:0] br_x;
  logic [XW-1:0] jal_x;
  logic [XW-1:0] jr_x;
  logic          unused_hi;
  logic          unused_lo;

  // immediate reassembly from the scattered instruction fields
  assign br_off  = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
  assign jal_off = {instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
  assign jr_imm  = instr[31:20];

  // sign-extend (or truncate) to the byte-address width of the PC
  assign br_x  = XW'($signed(br_off));
  assign jal_x = XW'($signed(jal_off));
  assign jr_x  = XW'($signed(jr_imm));

  // word targets: drop the two byte bits before adding
  assign br_tgt   = pc_ex + br_x[XW-1:2];
  assign jal_tgt  = pc_ex + jal_x[XW-1:2];
  assign jalr_tgt = rs1_data[XW-1:2] + jr_x[XW-1:2];

  generate
    if (XLEN > XW) begin : g_rs1_wide
      assign unused_hi = ^rs1_data[XLEN-1:XW];
    end else begin : g_rs1_fit
      assign unused_hi = 1'b0;
    end
  endgenerate

  assign unused_lo = ^{instr[6:0], rs1_data[1:0], br_x[1:0], jal_x[1:0], jr_x[1:0]};
endmodule

// File: rtl/fetch_resolve.sv
module fetch_resolve
  import fetch_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [6:0]      opcode,
  input  logic [2:0]      funct3,
  input  logic [XLEN-1:0] alu_result,
  input  logic            slot_live,
  output npc_sel_e        sel,
  output logic            link_we
);
  logic res_zero;
  logic res_one;
  logic cond_met;

  assign res_zero = (alu_result == '0);
  assign res_one  = (alu_result == XLEN'(1));

  always_comb begin
    unique case (funct3)
      CND_EQ:           cond_met = res_zero;
      CND_NE:           cond_met = !res_zero;
      CND_LT, CND_LTU:  cond_met = res_one;
      CND_GE, CND_GEU:  cond_met = res_zero;
      default:          cond_met = 1'b0;
    endcase
  end

  always_comb begin
    sel     = NPC_SEQ;
    link_we = 1'b0;
    if (slot_live) begin
      unique case (opcode)
        OPC_BRANCH: begin
          if (cond_met) sel = NPC_BRANCH;
        end
        OPC_JAL: begin
          sel     = NPC_JAL;
          link_we = 1'b1;
        end
        OPC_JALR: begin
          if (funct3 == 3'b000) begin
            sel     = NPC_JALR;
            link_we = 1'b1;
          end
        end
        default: begin
          sel     = NPC_SEQ;
          link_we = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/fetch_next_pc.sv
module fetch_next_pc
  import fetch_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  npc_sel_e        sel,
  input  logic [PC_W-1:0] pc_fetch,
  input  logic [PC_W-1:0] br_tgt,
  input  logic [PC_W-1:0] jal_tgt,
  input  logic [PC_W-1:0] jalr_tgt,
  output logic [PC_W-1:0] pc_next
);
  always_comb begin
    unique case (sel)
      NPC_BRANCH: pc_next = br_tgt;
      NPC_JAL:    pc_next = jal_tgt;
      NPC_JALR:   pc_next = jalr_tgt;
      default:    pc_next = pc_fetch + PC_W'(1);
    endcase
  end
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int PC_W = 12,
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  input  logic [XLEN-1:0]    alu_result,
  input  logic [XLEN-1:0]    rs1_data,
  output logic [PC_W-1:0]    pc_ex,
  output logic [INSTR_W-1:0] instr_ex,
  output logic               stall_ex,
  output logic [1:0]         pc_sel,
  output logic               redirect,
  output logic               link_we,
  output logic [XLEN-1:0]    link_data
);
  logic [PC_W-1:0] pc_fetch_q;
  logic [PC_W-1:0] pc_ex_q;
  logic [31:0]     instr_q;
  logic            stall_q;
  logic [PC_W-1:0] br_tgt;
  logic [PC_W-1:0] jal_tgt;
  logic [PC_W-1:0] jalr_tgt;
  logic [PC_W-1:0] pc_next;
  npc_sel_e        sel;

  fetch_target_gen #(.PC_W(PC_W), .XLEN(XLEN)) u_tgt (
    .instr    (instr_q),
    .pc_ex    (pc_ex_q),
    .rs1_data (rs1_data),
    .br_tgt   (br_tgt),
    .jal_tgt  (jal_tgt),
    .jalr_tgt (jalr_tgt)
  );

  fetch_resolve #(.XLEN(XLEN)) u_res (
    .opcode     (instr_q[6:0]),
    .funct3     (instr_q[14:12]),
    .alu_result (alu_result),
    .slot_live  (!stall_q),
    .sel        (sel),
    .link_we    (link_we)
  );

  fetch_next_pc #(.PC_W(PC_W)) u_npc (
    .sel      (sel),
    .pc_fetch (pc_fetch_q),
    .br_tgt   (br_tgt),
    .jal_tgt  (jal_tgt),
    .jalr_tgt (jalr_tgt),
    .pc_next  (pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_fetch_q <= '0;
      pc_ex_q    <= '0;
      instr_q    <= '0;
      stall_q    <= 1'b0;
    end else begin
      pc_fetch_q <= pc_next;
      pc_ex_q    <= pc_fetch_q;
      instr_q    <= imem_data;
      stall_q    <= (sel != NPC_SEQ);
    end
  end

  assign imem_addr = pc_fetch_q;
  assign pc_ex     = pc_ex_q;
  assign instr_ex  = instr_q;
  assign stall_ex  = stall_q;
  assign pc_sel    = sel;
  assign redirect  = (sel != NPC_SEQ);
  assign link_data = XLEN'({pc_fetch_q, 2'b00});
endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
  parameter int PC_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] imem_addr,
  input logic [PC_W-1:0] pc_ex,
  input logic            stall_ex,
  input logic            redirect,
  input logic            link_we
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (imem_addr == '0 && pc_ex == '0 && !stall_ex));

  p_pc_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && !redirect) |=> (imem_addr == PC_W'($past(imem_addr) + 1'b1)));

  p_pc_ex_follows_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (pc_ex == $past(imem_addr)));

  p_redirect_stalls_r7: assert property (@(posedge clk) disable iff (rst)
    (!rst && redirect) |=> stall_ex);

  p_stall_one_slot_r7: assert property (@(posedge clk) disable iff (rst)
    (!rst && !redirect) |=> !stall_ex);

  p_dead_slot_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    stall_ex |-> (!redirect && !link_we));
endmodule

bind fetch_unit fetch_unit_chk #(.PC_W(PC_W)) u_fetch_chk (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .pc_ex     (pc_ex),
  .stall_ex  (stall_ex),
  .redirect  (redirect),
  .link_we   (link_we)
);

// File: tb/fetch_unit_tb_top.sv
module fetch_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic        clk;
  logic        rst;
  logic [11:0] imem_addr;
  logic [31:0] imem_data;
  logic [31:0] alu_result;
  logic [31:0] rs1_data;
  logic [11:0] pc_ex;
  logic [31:0] instr_ex;
  logic        stall_ex;
  logic [1:0]  pc_sel;
  logic        redirect;
  logic        link_we;
  logic [31:0] link_data;

  int n_checks;
  int n_err;
  int cyc;

  bit          prog_mode;
  logic [31:0] prog [0:15];
  logic [31:0] regs [0:31];
  logic [31:0] w0, wp, wn;
  logic [11:0] place, place_n1;
  logic [31:0] sw_alu, sw_rs1;

  fetch_unit #(.PC_W(12), .XLEN(32)) dut_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .alu_result(alu_result), .rs1_data(rs1_data), .pc_ex(pc_ex),
    .instr_ex(instr_ex), .stall_ex(stall_ex), .pc_sel(pc_sel),
    .redirect(redirect), .link_we(link_we), .link_data(link_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- encoders ----------------
  function automatic logic [31:0] enc_b(input logic [2:0] f3, input logic [4:0] a,
                                        input logic [4:0] b, input int off);
    logic [12:0] o;
    o = 13'(off);
    return {o[12], o[10:5], b, a, f3, o[4:1], o[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] enc_j(input logic [4:0] rd, input int off);
    logic [20:0] o;
    o = 21'(off);
    return {o[20], o[10:1], o[11], o[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [31:0] enc_i(input logic [6:0] op, input logic [4:0] rd,
                                        input logic [2:0] f3, input logic [4:0] a,
                                        input int imm);
    logic [11:0] m;
    m = 12'(imm);
    return {m, a, f3, rd, op};
  endfunction

  function automatic bit cond_expect(input logic [2:0] f3, input logic [31:0] a);
    case (f3)
      3'b000: return a == 0;
      3'b001: return a != 0;
      3'b100, 3'b110: return a == 1;
      3'b101, 3'b111: return a == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] alu_pick(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h0000_0002;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // ---------------- environment models ----------------
  always_comb begin
    if (prog_mode)
      imem_data = (imem_addr < 12'd16) ? prog[imem_addr[3:0]] : NOP;
    else if (imem_addr == 12'd0)
      imem_data = w0;
    else if (imem_addr == place)
      imem_data = wp;
    else if (imem_addr == place_n1)
      imem_data = wn;
    else
      imem_data = NOP;
  end

  always_comb begin
    logic [31:0] va, vb;
    va = regs[instr_ex[19:15]];
    vb = regs[instr_ex[24:20]];
    if (prog_mode) begin
      rs1_data = va;
      case (instr_ex[14:13])
        2'b00:   alu_result = va - vb;
        2'b10:   alu_result = {31'b0, $signed(va) < $signed(vb)};
        2'b11:   alu_result = {31'b0, va < vb};
        default: alu_result = 32'b0;
      endcase
    end else begin
      rs1_data   = sw_rs1;
      alu_result = sw_alu;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) regs[i] <= 32'b0;
    end else if (prog_mode && !stall_ex && instr_ex[11:7] != 5'd0) begin
      if (instr_ex[6:0] == 7'h13)
        regs[instr_ex[11:7]] <= regs[instr_ex[19:15]] + {{20{instr_ex[31]}}, instr_ex[31:20]};
      else if (instr_ex[6:0] == 7'h6f || instr_ex[6:0] == 7'h67)
        regs[instr_ex[11:7]] <= {18'b0, pc_ex + 12'd1, 2'b00};
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(imem_addr == 12'd0, "R1", "fetch addr in reset", 32'(imem_addr), 0);
    check(pc_ex == 12'd0, "R1", "exec addr in reset", 32'(pc_ex), 0);
    check(instr_ex == 32'd0, "R1", "exec instr in reset", instr_ex, 0);
    check(stall_ex == 1'b0, "R1", "stall in reset", 32'(stall_ex), 0);
    rst = 1'b0;
  endtask

  task automatic run_case(input logic [31:0] w, input logic [11:0] pl,
                          input logic [31:0] a, input logic [31:0] r,
                          input logic [1:0] exp_sel, input logic [11:0] tgt,
                          input string req);
    int  waited;
    bit  taken;
    bit  is_link;
    prog_mode = 1'b0;
    wp        = w;
    place     = pl;
    place_n1  = pl + 12'd1;
    w0        = enc_j(5'd0, int'(pl) * 4);
    wn        = enc_j(5'd1, 400);
    sw_alu    = a;
    sw_rs1    = r;
    do_reset();
    waited = 0;
    while (!(pc_ex == pl && !stall_ex) && waited < 12) begin
      @(negedge clk);
      waited++;
    end
    check(waited < 12, "R5", "reach placed word", 32'(pc_ex), 32'(pl));
    taken   = (exp_sel != 2'b00);
    is_link = (w[6:0] == 7'h6f) || (w[6:0] == 7'h67 && w[14:12] == 3'b000);
    check(pc_sel == exp_sel, req, "select code", 32'(pc_sel), 32'(exp_sel));
    check(redirect == taken, "R10", "redirect flag", 32'(redirect), 32'(taken));
    if (is_link) begin
      check(link_we == 1'b1, "R9", "link write", 32'(link_we), 1);
      check(link_data == {18'b0, pl + 12'd1, 2'b00}, "R9", "link value",
            link_data, {18'b0, pl + 12'd1, 2'b00});
    end else begin
      check(link_we == 1'b0, "R9", "no link write", 32'(link_we), 0);
    end
    @(negedge clk);
    check(imem_addr == (taken ? tgt : pl + 12'd2), req, "next fetch addr",
          32'(imem_addr), 32'(taken ? tgt : pl + 12'd2));
    check(stall_ex == taken, "R7", "stall after transfer", 32'(stall_ex), 32'(taken));
    check(pc_ex == pl + 12'd1, "R2", "exec addr follows", 32'(pc_ex), 32'(pl + 12'd1));
    if (taken) begin
      check(!redirect && !link_we, "R8", "dead jump quiet", {30'b0, redirect, link_we}, 0);
      @(negedge clk);
      check(imem_addr == tgt + 12'd1, "R8", "fetch after dead slot",
            32'(imem_addr), 32'(tgt + 12'd1));
      check(stall_ex == 1'b0, "R7", "single stall slot", 32'(stall_ex), 0);
    end
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int          seq [0:16];
    bit          stl [0:16];
    int          o;
    logic [11:0] pl;
    logic [31:0] a;
    logic [31:0] r;
    bit          tk;
    logic [31:0] wi;
    int          jimm;

    n_checks  = 0;
    n_err     = 0;
    cyc       = 0;
    rst       = 1'b1;
    prog_mode = 1'b1;
    w0 = NOP; wp = NOP; wn = NOP; place = 12'd2; place_n1 = 12'd3;
    sw_alu = 0; sw_rs1 = 0;

    prog[0]  = enc_i(7'h13, 5'd4, 3'b000, 5'd0, -1);
    prog[1]  = enc_i(7'h13, 5'd5, 3'b000, 5'd0, 2);
    prog[2]  = enc_b(3'b000, 5'd4, 5'd5, 6 * 4);
    prog[3]  = enc_b(3'b001, 5'd4, 5'd5, 5 * 4);
    prog[4]  = enc_b(3'b100, 5'd4, 5'd5, 5 * 4);
    prog[5]  = enc_j(5'd1, 5 * 4);
    prog[6]  = enc_j(5'd0, 8 * 4);
    prog[7]  = NOP;
    prog[8]  = enc_j(5'd1, -4 * 4);
    prog[9]  = enc_i(7'h67, 5'd1, 3'b000, 5'd1, 0);
    prog[10] = enc_b(3'b101, 5'd4, 5'd5, -6 * 4);
    prog[11] = enc_b(3'b111, 5'd4, 5'd5, 2 * 4);
    prog[12] = enc_b(3'b000, 5'd0, 5'd0, -8 * 4);
    prog[13] = enc_b(3'b110, 5'd4, 5'd4, -9 * 4);
    prog[14] = enc_j(5'd0, 0);
    prog[15] = NOP;

    seq = '{0, 1, 2, 3, 4, 8, 9, 4, 5, 9, 10, 9, 10, 10, 11, 12, 13};
    stl = '{0, 0, 0, 0, 1, 0, 1, 0, 1, 0, 1,  0, 1,  0,  0,  1,  0};

    // R11: chained redirects through a small program
    do_reset();
    for (int i = 0; i < 17; i++) begin
      @(negedge clk);
      check(pc_ex == 12'(seq[i]), "R11", "exec word order", 32'(pc_ex), 32'(seq[i]));
      check(stall_ex == stl[i], "R11", "stall marking", 32'(stall_ex), 32'(stl[i]));
      check(instr_ex == prog[seq[i]], "R2", "exec instruction", instr_ex, prog[seq[i]]);
      if (!stl[i] && (prog[seq[i]][6:0] == 7'h6f || prog[seq[i]][6:0] == 7'h67))
        check(link_we && link_data == 32'((seq[i] + 1) * 4), "R9", "program link",
              link_data, 32'((seq[i] + 1) * 4));
    end

    // R3/R4: every condition code against several ALU results
    for (int f = 0; f < 8; f++) begin
      for (int k = 0; k < 4; k++) begin
        a  = alu_pick(k);
        o  = ((f * 97 + k * 53) % 2048) - 1024;
        pl = 12'((f * 512 + k * 97 + 5) % 4096);
        tk = cond_expect(3'(f), a);
        run_case(enc_b(3'(f), 5'd2, 5'd3, o * 4), pl, a, 32'h0,
                 tk ? 2'b01 : 2'b00, 12'(int'(pl) + o), tk ? "R3" : "R4");
      end
    end

    // R5: direct jumps, forward, backward and wrapping
    for (int i = 0; i < 8; i++) begin
      case (i)
        0: o = 1;     1: o = -1;   2: o = 0;   3: o = 2047;
        4: o = -3000; 5: o = 5000; 6: o = 100; default: o = -5;
      endcase
      pl = 12'(300 + i * 400);
      run_case(enc_j(5'd1, o * 4), pl, 32'h0, 32'h0, 2'b10,
               12'(int'(pl) + o), "R5");
    end

    // R6: register jumps, target independent of the jump's own address
    for (int i = 0; i < 8; i++) begin
      case (i)
        0: begin r = 32'h0000_0000; jimm = 0;     end
        1: begin r = 32'h0000_3FFC; jimm = -4;    end
        2: begin r = 32'hFFFF_1235; jimm = 2047;  end
        3: begin r = 32'h1234_5678; jimm = -2048; end
        4: begin r = 32'h0000_0007; jimm = 5;     end
        5: begin r = 32'h0000_0010; jimm = -1;    end
        6: begin r = 32'h0000_2403; jimm = 8;     end
        default: begin r = 32'h8000_0004; jimm = 1024; end
      endcase
      pl = 12'(2000 + i * 7);
      run_case(enc_i(7'h67, 5'd1, 3'b000, 5'd3, jimm), pl, 32'h0, r, 2'b11,
               12'(int'(r[13:2]) + (jimm >>> 2)), "R6");
    end

    // R6: other code under the register-jump opcode is not a transfer
    run_case(enc_i(7'h67, 5'd1, 3'b001, 5'd3, 64), 12'd50, 32'h0, 32'h100,
             2'b00, 12'd0, "R6");
    // R10: ordinary arithmetic word selects the sequential path
    wi = enc_i(7'h13, 5'd6, 3'b000, 5'd0, 9);
    run_case(wi, 12'd4094, 32'h0, 32'h0, 2'b00, 12'd0, "R10");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule